// File: doc/BRIEF.md
# Multi-Mode Timer with Variable-Width PWM

This block is a 16-bit counting unit built from two byte-wide counters. A two-bit mode input chooses how the pair is used: as two separate 8-bit interval timers, as an 8-bit interval timer beside an 8-bit pulse-width modulator, as one cascaded 16-bit interval timer, or as a pulse-width modulator whose period spans 9 to 16 bits. The counters move on count-enable strobes supplied by the surrounding chip: one strobe arrives once per machine cycle and another twice per machine cycle.

Two byte inputs hold the match values in the timer modes and the compare value in the PWM modes. The unit copies each byte into a private shadow copy only at that counter's period boundary, or while the unit is stopped, so a value written mid-period never shortens or stretches the running period or pulse. A run input stops the unit, clears both counters and silences every output. Overflow flags are single-clock pulses that a separate interrupt block can pick up.

Top module: `tpw_timer_unit`

## Requirements
- R1: With mode 2'b00 the low and high bytes are separate timers. Each one counts up from zero and, on the tick on which its count equals its match byte, returns to zero and raises its own overflow flag. Its overflows therefore come every (match+1) ticks, whatever the other byte is set to.
- R2: With mode 2'b01 the low byte is a timer as in R1. The high byte counts freely through 256 ticks and raises ovf_hi when it wraps from 255 to 0. pwm_out is high while that count is below the high compare byte, which gives 2*cmp high clocks in each 512-clock period at one tick every two clocks.
- R3: With mode 2'b10 both bytes form one 16-bit counter matched against {hi_val, lo_val}. ovf_hi pulses every (match+1) ticks and ovf_lo stays low.
- R4: With mode 2'b11 the 16-bit counter wraps after 2^N ticks, where N = 9 + width_sel. ovf_hi pulses at each wrap and ovf_lo stays low.
- R5: With mode 2'b11 pwm_out is high while the count is below the 16-bit compare value {hi_val, lo_val}. Each period therefore has min(cmp, 2^N) high ticks: a compare of zero keeps the output low and a compare of 2^N or more keeps it high.
- R6: In modes 2'b00 and 2'b01 the counters advance only on tick_full, and half_res has no effect.
- R7: In modes 2'b10 and 2'b11 the counters advance on tick_half when half_res is 1 and on tick_full when it is 0.
- R8: A change to lo_val or hi_val during a period takes effect at the next period boundary of the counter that uses it. The running period and pulse are left unchanged.
- R9: While run is 0 both counters are held at zero, pwm_out is low and neither overflow flag pulses. After run is raised the first overflow comes after exactly (match+1) ticks.
- R10: An overflow flag is high for the one clock that follows the wrapping tick. pwm_out is always low in modes 2'b00 and 2'b10.
- R11: During reset all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_full | input | 1 | Count strobe, once per machine cycle |
| tick_half | input | 1 | Count strobe, twice per machine cycle |
| mode | input | 2 | Mode select: 00 dual timer, 01 timer plus PWM, 10 16-bit timer, 11 variable PWM |
| width_sel | input | 3 | Variable PWM width, N = 9 + width_sel |
| half_res | input | 1 | In modes 10 and 11, count on tick_half |
| run | input | 1 | 1 runs the unit; 0 clears and silences it |
| lo_val | input | 8 | Low match or compare byte |
| hi_val | input | 8 | High match or compare byte |
| ovf_lo | output | 1 | Low-byte overflow pulse |
| ovf_hi | output | 1 | High-byte or 16-bit overflow pulse |
| pwm_out | output | 1 | PWM output |

## Verification
The assertions check on every cycle that a stopped unit stays silent, that pwm_out stays low in the timer-only modes, and that ovf_lo never pulses in the 16-bit modes. They also check that a low-byte overflow always follows a machine-cycle strobe and that variable-width overflows are isolated pulses. Exact period lengths, duty counts across the widths, the choice of resolution, the deferred loading of new match and compare values, and the restart timing after run rises can only be shown by the bench's scenarios. The bench measures these between overflow pulses and compares them with values it works out from the requirements.

// File: rtl/tpw_pkg.sv
package tpw_pkg;
  typedef enum logic [1:0] {
    MODE_DUAL8 = 2'b00,
    MODE_T8P8  = 2'b01,
    MODE_T16   = 2'b10,
    MODE_PVAR  = 2'b11
  } tpw_mode_e;

  localparam int LANES = 2;
  localparam int LANE_LO = 0;
  localparam int LANE_HI = 1;
endpackage

// File: rtl/tpw_tick_sel.sv
module tpw_tick_sel (
  input  logic       tick_full,
  input  logic       tick_half,
  input  logic [1:0] mode,
  input  logic       half_res,
  output logic       adv
);
  import tpw_pkg::*;

  always_comb begin
    if (mode == MODE_T16 || mode == MODE_PVAR) begin
      adv = half_res ? tick_half : tick_full;
    end else begin
      adv = tick_full;
    end
  end
endmodule

// File: rtl/tpw_lane.sv
module tpw_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] din,
  output logic [W-1:0] cnt,
  output logic [W-1:0] shd
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] shd_q, shd_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (inc) begin
      cnt_d = cnt_q + 1'b1;
    end
    shd_d = shd_q;
    if (ld) begin
      shd_d = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      shd_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      shd_q <= shd_d;
    end
  end

  assign cnt = cnt_q;
  assign shd = shd_q;
endmodule

// File: rtl/tpw_ctl.sv
module tpw_ctl #(
  parameter int BYTE_W    = 8,
  parameter int WSEL_W    = 3,
  parameter int MIN_PWM_W = 9
) (
  input  logic [1:0]        mode,
  input  logic              run,
  input  logic              adv,
  input  logic [WSEL_W-1:0] width_sel,
  input  logic [BYTE_W-1:0] cnt_lo,
  input  logic [BYTE_W-1:0] cnt_hi,
  input  logic [BYTE_W-1:0] shd_lo,
  input  logic [BYTE_W-1:0] shd_hi,
  output logic [1:0]        inc,
  output logic [1:0]        clr,
  output logic [1:0]        ld,
  output logic              ovf_lo_d,
  output logic              ovf_hi_d,
  output logic              pwm
);
  import tpw_pkg::*;

  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0] cnt16;
  logic [CNT_W-1:0] ref16;
  logic [CNT_W-1:0] top16;
  logic             carry;
  logic             lo_wrap;
  logic             hi_wrap;
  logic             w16;
  int               pwm_w;

  assign cnt16 = {cnt_hi, cnt_lo};
  assign ref16 = {shd_hi, shd_lo};
  assign carry = adv && (cnt_lo == {BYTE_W{1'b1}});

  // all-ones value N bits wide, N chosen at run time
  always_comb begin
    pwm_w = MIN_PWM_W + int'(width_sel);
    for (int i = 0; i < CNT_W; i++) begin
      top16[i] = (i < pwm_w);
    end
  end

  always_comb begin
    inc      = '0;
    clr      = '0;
    ld       = '0;
    ovf_lo_d = 1'b0;
    ovf_hi_d = 1'b0;
    pwm      = 1'b0;
    lo_wrap  = adv && (cnt_lo == shd_lo);
    hi_wrap  = 1'b0;
    w16      = 1'b0;
    if (!run) begin
      clr = 2'b11;
      ld  = 2'b11;
    end else begin
      unique case (mode)
        MODE_DUAL8: begin
          hi_wrap          = adv && (cnt_hi == shd_hi);
          inc              = {adv, adv};
          clr              = {hi_wrap, lo_wrap};
          ld               = {hi_wrap, lo_wrap};
          ovf_lo_d         = lo_wrap;
          ovf_hi_d         = hi_wrap;
        end
        MODE_T8P8: begin
          hi_wrap          = adv && (cnt_hi == {BYTE_W{1'b1}});
          inc              = {adv, adv};
          clr              = {hi_wrap, lo_wrap};
          ld               = {hi_wrap, lo_wrap};
          ovf_lo_d         = lo_wrap;
          ovf_hi_d         = hi_wrap;
          pwm              = (cnt_hi < shd_hi);
        end
        MODE_T16: begin
          w16              = adv && (cnt16 == ref16);
          inc              = {carry, adv};
          clr              = {w16, w16};
          ld               = {w16, w16};
          ovf_hi_d         = w16;
        end
        default: begin
          w16              = adv && (cnt16 == top16);
          inc              = {carry, adv};
          clr              = {w16, w16};
          ld               = {w16, w16};
          ovf_hi_d         = w16;
          pwm              = (cnt16 < ref16);
        end
      endcase
    end
  end
endmodule

// File: rtl/tpw_timer_unit.sv
module tpw_timer_unit #(
  parameter int BYTE_W    = 8,
  parameter int WSEL_W    = 3,
  parameter int MIN_PWM_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_full,
  input  logic              tick_half,
  input  logic [1:0]        mode,
  input  logic [WSEL_W-1:0] width_sel,
  input  logic              half_res,
  input  logic              run,
  input  logic [BYTE_W-1:0] lo_val,
  input  logic [BYTE_W-1:0] hi_val,
  output logic              ovf_lo,
  output logic              ovf_hi,
  output logic              pwm_out
);
  import tpw_pkg::*;

  logic                         adv;
  logic [LANES-1:0]             inc, clr, ld;
  logic [LANES-1:0][BYTE_W-1:0] din_v, cnt_v, shd_v;
  logic                         ovf_lo_d, ovf_hi_d, pwm_c;
  logic                         ovf_lo_q, ovf_hi_q;

  assign din_v[LANE_LO] = lo_val;
  assign din_v[LANE_HI] = hi_val;

  tpw_tick_sel u_tick (
    .tick_full (tick_full),
    .tick_half (tick_half),
    .mode      (mode),
    .half_res  (half_res),
    .adv       (adv)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tpw_lane #(.W(BYTE_W)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (inc[g]),
      .clr   (clr[g]),
      .ld    (ld[g]),
      .din   (din_v[g]),
      .cnt   (cnt_v[g]),
      .shd   (shd_v[g])
    );
  end

  tpw_ctl #(
    .BYTE_W    (BYTE_W),
    .WSEL_W    (WSEL_W),
    .MIN_PWM_W (MIN_PWM_W)
  ) u_ctl (
    .mode      (mode),
    .run       (run),
    .adv       (adv),
    .width_sel (width_sel),
    .cnt_lo    (cnt_v[LANE_LO]),
    .cnt_hi    (cnt_v[LANE_HI]),
    .shd_lo    (shd_v[LANE_LO]),
    .shd_hi    (shd_v[LANE_HI]),
    .inc       (inc),
    .clr       (clr),
    .ld        (ld),
    .ovf_lo_d  (ovf_lo_d),
    .ovf_hi_d  (ovf_hi_d),
    .pwm       (pwm_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_lo_q <= 1'b0;
      ovf_hi_q <= 1'b0;
    end else begin
      ovf_lo_q <= ovf_lo_d;
      ovf_hi_q <= ovf_hi_d;
    end
  end

  assign ovf_lo  = ovf_lo_q;
  assign ovf_hi  = ovf_hi_q;
  assign pwm_out = pwm_c;
endmodule

// File: rtl/tpw_timer_sva.sv
module tpw_timer_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_full,
  input logic [1:0] mode,
  input logic       run,
  input logic       ovf_lo,
  input logic       ovf_hi,
  input logic       pwm_out
);
  a_r9_idle_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!ovf_lo && !ovf_hi));

  a_r9_idle_pwm_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !pwm_out);

  a_r10_pwm_low_timer_modes: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 || mode == 2'b10) |-> !pwm_out);

  a_r3_no_lo_ovf_wide: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode[1]) |=> !ovf_lo);

  a_r6_lo_ovf_after_full_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_lo |-> $past(tick_full));

  a_r4_single_wrap_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode == 2'b11 && ovf_hi) |=> !ovf_hi);
endmodule

bind tpw_timer_unit tpw_timer_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_full (tick_full),
  .mode      (mode),
  .run       (run),
  .ovf_lo    (ovf_lo),
  .ovf_hi    (ovf_hi),
  .pwm_out   (pwm_out)
);

// File: tb/tpw_timer_unit_test.sv
module tpw_timer_unit_test;
  localparam int LIMIT = 70000;

  logic       clk, rst_n, tick_full, tick_half, half_res, run;
  logic [1:0] mode;
  logic [2:0] width_sel;
  logic [7:0] lo_val, hi_val;
  logic       ovf_lo, ovf_hi, pwm_out;

  int checks = 0;
  int errors = 0;

  tpw_timer_unit uut (
    .clk(clk), .rst_n(rst_n), .tick_full(tick_full), .tick_half(tick_half),
    .mode(mode), .width_sel(width_sel), .half_res(half_res), .run(run),
    .lo_val(lo_val), .hi_val(hi_val),
    .ovf_lo(ovf_lo), .ovf_hi(ovf_hi), .pwm_out(pwm_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // machine-cycle strobe: every other clock; half strobe: every clock
  initial begin
    tick_full = 1'b0;
    tick_half = 1'b1;
    forever @(negedge clk) tick_full = ~tick_full;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setup(input logic [1:0] m, input logic [2:0] w, input logic h,
                       input logic [7:0] lo, input logic [7:0] hi);
    @(negedge clk);
    run = 1'b0;
    repeat (3) @(negedge clk);
    mode = m; width_sel = w; half_res = h; lo_val = lo; hi_val = hi;
    @(negedge clk);
    run = 1'b1;
  endtask

  task automatic wait_pulse(input bit hi_sel, output bit ok);
    ok = 1'b0;
    for (int n = 0; n < LIMIT; n++) begin
      @(negedge clk);
      if (hi_sel ? ovf_hi : ovf_lo) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  // clocks between two overflow pulses; optionally rewrites lo_val mid-period
  task automatic measure_ovf(input bit hi_sel, input int chg_at, input logic [7:0] chg_lo,
                             output int interval, output int lo_seen);
    bit ok;
    interval = -1;
    lo_seen = 0;
    wait_pulse(hi_sel, ok);
    if (!ok) return;
    interval = 0;
    for (int n = 0; n < LIMIT; n++) begin
      @(negedge clk);
      interval++;
      if (interval == chg_at) lo_val = chg_lo;
      lo_seen += int'(ovf_lo);
      if (hi_sel ? ovf_hi : ovf_lo) return;
    end
    interval = -1;
  endtask

  // high clocks and period length between two ovf_hi pulses
  task automatic measure_pwm(input int chg_at, input logic [15:0] chg_cmp,
                             output int highs, output int period, output int lo_seen);
    bit ok;
    highs = -1; period = -1; lo_seen = 0;
    wait_pulse(1'b1, ok);
    if (!ok) return;
    highs = int'(pwm_out);
    period = 0;
    for (int n = 0; n < LIMIT; n++) begin
      @(negedge clk);
      period++;
      if (period == chg_at) {hi_val, lo_val} = chg_cmp;
      lo_seen += int'(ovf_lo);
      if (ovf_hi) return;
      highs += int'(pwm_out);
    end
    period = -1;
  endtask

  initial begin
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int iv, lo_seen, hi_cnt, per, bad;
    int mlist [6] = '{0, 1, 3, 7, 100, 255};
    int pcmp [4] = '{0, 1, 128, 255};
    int m16 [4] = '{1, 255, 256, 4660};
    int wl [6] = '{0, 1, 2, 3, 4, 6};
    int cl [6] = '{0, 341, 65535, 2048, 4096, 32768};

    rst_n = 1'b0; run = 1'b0; mode = 2'b00; width_sel = 3'd0; half_res = 1'b0;
    lo_val = 8'd0; hi_val = 8'd0;
    repeat (4) @(negedge clk);
    check("R11 reset outputs", int'({ovf_lo, ovf_hi, pwm_out}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 outputs after reset", int'({ovf_lo, ovf_hi, pwm_out}), 0);

    // R1 / R6: dual 8-bit timers, half_res toggled but ignored
    foreach (mlist[i]) begin
      setup(2'b00, 3'd0, logic'(i % 2), 8'(mlist[i]), 8'(mlist[5 - i]));
      measure_ovf(1'b0, -1, 8'd0, iv, lo_seen);
      check("R1 R6 mode0 low interval", iv, 2 * (mlist[i] + 1));
      measure_ovf(1'b1, -1, 8'd0, iv, lo_seen);
      check("R1 R6 mode0 high interval", iv, 2 * (mlist[5 - i] + 1));
    end

    // R2 / R6: timer plus 8-bit PWM
    foreach (pcmp[i]) begin
      setup(2'b01, 3'd0, 1'b1, 8'd9, 8'(pcmp[i]));
      measure_pwm(-1, 16'd0, hi_cnt, per, lo_seen);
      check("R2 R6 mode1 pwm period", per, 512);
      check("R2 mode1 pwm high clocks", hi_cnt, 2 * pcmp[i]);
    end
    measure_ovf(1'b0, -1, 8'd0, iv, lo_seen);
    check("R2 mode1 low timer interval", iv, 20);

    // R3 / R7: 16-bit timer, half resolution
    foreach (m16[i]) begin
      setup(2'b10, 3'd0, 1'b1, 8'(m16[i] % 256), 8'(m16[i] / 256));
      measure_ovf(1'b1, -1, 8'd0, iv, lo_seen);
      check("R3 R7 mode2 interval half", iv, m16[i] + 1);
      check("R3 mode2 ovf_lo silent", lo_seen, 0);
    end
    setup(2'b10, 3'd0, 1'b0, 8'h23, 8'h01);
    measure_ovf(1'b1, -1, 8'd0, iv, lo_seen);
    check("R7 mode2 interval full", iv, 2 * (16'h0123 + 1));

    // R4 / R5 / R7: variable-width PWM
    foreach (wl[i]) begin
      setup(2'b11, 3'(wl[i]), 1'b1, 8'(cl[i] % 256), 8'(cl[i] / 256));
      measure_pwm(-1, 16'd0, hi_cnt, per, lo_seen);
      check("R4 mode3 period", per, 1 << (9 + wl[i]));
      check("R5 mode3 high clocks", hi_cnt,
            (cl[i] < (1 << (9 + wl[i]))) ? cl[i] : (1 << (9 + wl[i])));
      check("R4 mode3 ovf_lo silent", lo_seen, 0);
    end
    setup(2'b11, 3'd0, 1'b0, 8'd200, 8'd0);
    measure_pwm(-1, 16'd0, hi_cnt, per, lo_seen);
    check("R7 mode3 period full res", per, 1024);
    check("R5 mode3 high full res", hi_cnt, 400);

    // R8: compare change mid-period waits for the boundary
    setup(2'b11, 3'd0, 1'b1, 8'd100, 8'd0);
    measure_pwm(5, 16'd300, hi_cnt, per, lo_seen);
    check("R8 mode3 old compare kept", hi_cnt, 100);
    measure_pwm(-1, 16'd0, hi_cnt, per, lo_seen);
    check("R8 mode3 new compare used", hi_cnt, 300);

    // R8: match change mid-period waits for the boundary
    setup(2'b00, 3'd0, 1'b0, 8'd50, 8'd255);
    measure_ovf(1'b0, 3, 8'd10, iv, lo_seen);
    check("R8 mode0 old match kept", iv, 102);
    measure_ovf(1'b0, -1, 8'd0, iv, lo_seen);
    check("R8 mode0 new match used", iv, 22);

    // R9: stopped unit is silent, restart counts from zero
    setup(2'b11, 3'd0, 1'b1, 8'hFF, 8'h01);
    repeat (100) @(negedge clk);
    run = 1'b0;
    bad = 0;
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      bad += int'(ovf_lo) + int'(ovf_hi) + int'(pwm_out);
    end
    check("R9 stopped outputs silent", bad, 0);
    mode = 2'b10; half_res = 1'b1; lo_val = 8'd20; hi_val = 8'd0;
    @(negedge clk);
    run = 1'b1;
    iv = -1;
    for (int n = 1; n < 200; n++) begin
      @(negedge clk);
      if (ovf_hi) begin
        iv = n;
        break;
      end
    end
    check("R9 R10 first overflow after restart", iv, 21);
    @(negedge clk);
    check("R10 overflow pulse one clock", int'(ovf_hi), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule